// File: doc/BRIEF.md
# Cluster Performance Monitor Counter Unit

This block counts hardware events for a processor cluster. It has a configurable number of 32-bit event counters and one 64-bit cycle counter. Each event counter is told which event code to watch. The events arrive as a 64-bit vector of one-cycle pulses, where bit k belongs to event code k. When a counter wraps past its maximum value, it records an overflow. The unit raises a single interrupt line when a recorded overflow belongs to a counter that has both counting and interrupts enabled.

Software reaches the block through a simple word-addressed register port. A write takes effect on the clock edge where `regWrEn` is high. Read data is combinational from `regAddr`. A read counts as an access on the edge where `regRdEn` is high, and only the overflow register reacts to that access.

Every per-counter bitmap uses the same layout: bit n belongs to event counter n, and bit 31 always belongs to the cycle counter.

Register map (7-bit word address):

| Address | Register |
|---|---|
| 0x00 | Control |
| 0x01 | Counter enable set |
| 0x02 | Counter enable clear |
| 0x03 | Interrupt enable set |
| 0x04 | Interrupt enable clear |
| 0x05 | Overflow status |
| 0x06 | Availability, low word |
| 0x07 | Availability, high word |
| 0x08 | Cycle counter, low word |
| 0x09 | Cycle counter, high word |
| 0x20+n | Value of event counter n |
| 0x40+n | Event type of event counter n (8 bits) |

Top module: `cluster_perf_monitor`

## Requirements
- R1: The control register (0x00) has the following layout:
  - bit 0 is the global enable, which is read/write and resets to 0;
  - bits 1 and 2 always read 0;
  - bits 10:3 read 0;
  - bits 15:11 hold the number of event counters;
  - bits 23:16 hold the ID_CODE parameter;
  - bits 31:24 hold the IMPL_CODE parameter.
- R2: Event counter n adds one on each clock edge where its selected code's input pulse is high, but only while the global enable and enable bit n are both set. Code 0x11 adds one on every such clock edge, whatever the input.
- R3: An event counter wraps from 0xFFFFFFFF to 0 and then sets overflow bit n. The 64-bit cycle counter wraps from all ones to 0 and then sets overflow bit 31.
- R4: Reading the overflow register (0x05) returns the set bits and clears them on that access edge. An overflow that happens on the same edge stays set.
- R5: `irqOut` is high exactly when some bit is set in all three of: the overflow status, the interrupt enable mask, and the counter enable mask.
- R6: Code 0x1E on an odd counter n adds one whenever counter n-1 wraps. On an even counter, code 0x1E never counts.
- R7: Writing control bit 1 as 1 zeroes every event counter. Writing control bit 2 as 1 zeroes the cycle counter. In both cases the zeroing takes priority over any increment on that edge.
- R8: A register write to a counter loads the written value, and the write takes priority over an increment on the same edge.
- R9: The availability words (0x06 = bits 31:0, 0x07 = bits 63:32) read back the EVT_AVAIL parameter. A code k below 64 whose bit k is clear never counts, and neither does any code of 64 or above. The default marks codes 0x11, 0x19, 0x1A, 0x1D, 0x1E and 0x29 to 0x2C as available.
- R10: For the enable and interrupt-enable masks, writing 1s to the set address sets those bits, and writing 1s to the clear address clears them. Both addresses read back the mask. Bits for counters that do not exist (n at or above the counter count, other than bit 31) always stay 0.
- R11: The cycle counter adds one on every clock edge while the global enable and enable bit 31 are both set. Its two words are individually readable and writable at 0x08 and 0x09.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtIn | input | 64 | One-cycle event pulses, bit k is event code k |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read access strobe |
| regAddr | input | 7 | Register word address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational) |
| irqOut | output | 1 | Overflow interrupt |

## Verification
The bench builds the unit with four event counters. With only four counters, the mask of unimplemented enable bits is easy to see, and one chained pair plus a stray even chain counter fit in a short run. With that small size, the bench can sweep every event code below 64, plus two codes above it, through counter 0, and compare each count with a value derived arithmetically from the availability list. Wraps are reached by preloading counters and the cycle counter just below their limit, so both the overflow on the same edge as a read and the 64-bit cycle wrap happen within a few cycles.

// File: rtl/pmon_pkg.sv
package pmon_pkg;

  localparam int ADDR_W     = 7;
  localparam int CYC_BIT    = 31;
  localparam logic [7:0] CODE_CYCLES = 8'h11;
  localparam logic [7:0] CODE_CHAIN  = 8'h1E;

  localparam logic [ADDR_W-1:0] A_CTRL   = 7'h00;
  localparam logic [ADDR_W-1:0] A_ENSET  = 7'h01;
  localparam logic [ADDR_W-1:0] A_ENCLR  = 7'h02;
  localparam logic [ADDR_W-1:0] A_IESET  = 7'h03;
  localparam logic [ADDR_W-1:0] A_IECLR  = 7'h04;
  localparam logic [ADDR_W-1:0] A_OVF    = 7'h05;
  localparam logic [ADDR_W-1:0] A_AVLO   = 7'h06;
  localparam logic [ADDR_W-1:0] A_AVHI   = 7'h07;
  localparam logic [ADDR_W-1:0] A_CYCLO  = 7'h08;
  localparam logic [ADDR_W-1:0] A_CYCHI  = 7'h09;
  localparam logic [1:0]        PG_CNT   = 2'b01;
  localparam logic [1:0]        PG_TYPE  = 2'b10;

  typedef struct packed {
    logic        rstEvt;
    logic        rstCyc;
    logic        evtWr;
    logic [4:0]  evtIdx;
    logic        cycLoWr;
    logic        cycHiWr;
    logic        ovfClr;
    logic [31:0] wrData;
  } pmon_strobe_t;

endpackage

// File: rtl/pmon_evt_slice.sv
module pmon_evt_slice #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         run,
  input  logic         hit,
  input  logic         load,
  input  logic         clear,
  input  logic [W-1:0] loadVal,
  output logic [W-1:0] value,
  output logic         wrap
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           value <= '0;
    else if (clear)      value <= '0;
    else if (load)       value <= loadVal;
    else if (run && hit) value <= value + 1'b1;
  end

  assign wrap = run && hit && !load && !clear && (&value);

  assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    load && !clear |=> value == $past(loadVal));

  assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !run && !load && !clear |=> value == $past(value));

  assert_wrap_to_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    wrap |=> value == '0);

endmodule

// File: rtl/pmon_datapath.sv
module pmon_datapath
  import pmon_pkg::*;
#(
  parameter int          NUM_CNT   = 6,
  parameter logic [63:0] EVT_AVAIL = 64'h0000_1E00_6602_0000
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [63:0]               evtIn,
  input  pmon_strobe_t              strobe,
  input  logic [31:0]               runMask,
  input  logic [NUM_CNT-1:0][7:0]   evtType,
  output logic [NUM_CNT-1:0][31:0]  evtCnt,
  output logic [63:0]               cycCnt,
  output logic [31:0]               ovfStatus
);

  localparam logic [63:0] AVAIL = EVT_AVAIL;

  logic [NUM_CNT-1:0] wrapVec;
  logic [NUM_CNT-1:0] hitVec;
  logic               cycWrap;
  logic [31:0]        setVec;
  logic [63:0]        cycLoadVal;

  for (genvar n = 0; n < NUM_CNT; n++) begin : g_cnt
    logic chainSrc;
    logic loadHere;

    if (n % 2 == 1) begin : g_odd
      assign chainSrc = wrapVec[n-1];
    end else begin : g_even
      assign chainSrc = 1'b0;
    end

    always_comb begin
      if (evtType[n] == CODE_CYCLES)     hitVec[n] = 1'b1;
      else if (evtType[n] == CODE_CHAIN) hitVec[n] = chainSrc;
      else if (evtType[n][7:6] == 2'b00) hitVec[n] = AVAIL[evtType[n][5:0]] & evtIn[evtType[n][5:0]];
      else                               hitVec[n] = 1'b0;
    end

    assign loadHere = strobe.evtWr && (strobe.evtIdx == 5'(n));

    pmon_evt_slice #(.W(32)) u_slice (
      .clk     (clk),
      .rstN    (rstN),
      .run     (runMask[n]),
      .hit     (hitVec[n]),
      .load    (loadHere),
      .clear   (strobe.rstEvt),
      .loadVal (strobe.wrData),
      .value   (evtCnt[n]),
      .wrap    (wrapVec[n])
    );
  end

  assign cycLoadVal = strobe.cycLoWr ? {cycCnt[63:32], strobe.wrData}
                                     : {strobe.wrData, cycCnt[31:0]};

  pmon_evt_slice #(.W(64)) u_cycle (
    .clk     (clk),
    .rstN    (rstN),
    .run     (runMask[CYC_BIT]),
    .hit     (1'b1),
    .load    (strobe.cycLoWr | strobe.cycHiWr),
    .clear   (strobe.rstCyc),
    .loadVal (cycLoadVal),
    .value   (cycCnt),
    .wrap    (cycWrap)
  );

  always_comb begin
    setVec              = '0;
    setVec[NUM_CNT-1:0] = wrapVec;
    setVec[CYC_BIT]     = cycWrap;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ovfStatus <= '0;
    else       ovfStatus <= (strobe.ovfClr ? 32'h0 : ovfStatus) | setVec;
  end

  assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ovfClr && (setVec == '0) |=> ovfStatus == '0);

  assert_wrap_records_R3: assert property (@(posedge clk) disable iff (!rstN)
    cycWrap |=> ovfStatus[CYC_BIT]);

  assert_chain_odd_only_R6: assert property (@(posedge clk) disable iff (!rstN)
    runMask[0] && evtType[0] == CODE_CHAIN && !strobe.evtWr && !strobe.rstEvt
    |=> evtCnt[0] == $past(evtCnt[0]));

endmodule

// File: rtl/pmon_ctrl.sv
module pmon_ctrl
  import pmon_pkg::*;
#(
  parameter int          NUM_CNT   = 6,
  parameter logic [7:0]  ID_CODE   = 8'h21,
  parameter logic [7:0]  IMPL_CODE = 8'h41,
  parameter logic [63:0] EVT_AVAIL = 64'h0000_1E00_6602_0000
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      regWrEn,
  input  logic                      regRdEn,
  input  logic [ADDR_W-1:0]         regAddr,
  input  logic [31:0]               regWrData,
  output logic [31:0]               regRdData,
  input  logic [NUM_CNT-1:0][31:0]  evtCnt,
  input  logic [63:0]               cycCnt,
  input  logic [31:0]               ovfStatus,
  output pmon_strobe_t              strobe,
  output logic [31:0]               runMask,
  output logic [NUM_CNT-1:0][7:0]   evtType,
  output logic                      irqOut
);

  localparam logic [31:0] IMPL_MASK = ((32'd1 << NUM_CNT) - 32'd1) | (32'd1 << CYC_BIT);

  logic        globalEn;
  logic [31:0] cntEn;
  logic [31:0] intEn;
  logic        inRange;
  logic        wrCnt, wrType;

  assign inRange = int'(regAddr[4:0]) < NUM_CNT;
  assign wrCnt   = regWrEn && (regAddr[6:5] == PG_CNT)  && inRange;
  assign wrType  = regWrEn && (regAddr[6:5] == PG_TYPE) && inRange;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      globalEn <= 1'b0;
      cntEn    <= '0;
      intEn    <= '0;
    end else if (regWrEn) begin
      case (regAddr)
        A_CTRL:  globalEn <= regWrData[0];
        A_ENSET: cntEn    <= cntEn | (regWrData & IMPL_MASK);
        A_ENCLR: cntEn    <= cntEn & ~regWrData;
        A_IESET: intEn    <= intEn | (regWrData & IMPL_MASK);
        A_IECLR: intEn    <= intEn & ~regWrData;
        default: ;
      endcase
    end
  end

  for (genvar n = 0; n < NUM_CNT; n++) begin : g_type
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                  evtType[n] <= '0;
      else if (wrType && regAddr[4:0] == 5'(n))   evtType[n] <= regWrData[7:0];
    end
  end

  always_comb begin
    strobe         = '0;
    strobe.rstEvt  = regWrEn && (regAddr == A_CTRL) && regWrData[1];
    strobe.rstCyc  = regWrEn && (regAddr == A_CTRL) && regWrData[2];
    strobe.evtWr   = wrCnt;
    strobe.evtIdx  = regAddr[4:0];
    strobe.cycLoWr = regWrEn && (regAddr == A_CYCLO);
    strobe.cycHiWr = regWrEn && (regAddr == A_CYCHI);
    strobe.ovfClr  = regRdEn && (regAddr == A_OVF);
    strobe.wrData  = regWrData;
  end

  assign runMask = globalEn ? cntEn : 32'h0;
  assign irqOut  = |(ovfStatus & intEn & cntEn);

  always_comb begin
    regRdData = '0;
    case (regAddr)
      A_CTRL:           regRdData = {IMPL_CODE, ID_CODE, 5'(NUM_CNT), 10'b0, globalEn};
      A_ENSET, A_ENCLR: regRdData = cntEn;
      A_IESET, A_IECLR: regRdData = intEn;
      A_OVF:            regRdData = ovfStatus;
      A_AVLO:           regRdData = EVT_AVAIL[31:0];
      A_AVHI:           regRdData = EVT_AVAIL[63:32];
      A_CYCLO:          regRdData = cycCnt[31:0];
      A_CYCHI:          regRdData = cycCnt[63:32];
      default: begin
        for (int n = 0; n < NUM_CNT; n++) begin
          if (regAddr[4:0] == 5'(n)) begin
            if (regAddr[6:5] == PG_CNT)  regRdData = evtCnt[n];
            if (regAddr[6:5] == PG_TYPE) regRdData = {24'b0, evtType[n]};
          end
        end
      end
    endcase
  end

  assert_enable_set_R10: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn && regAddr == A_ENSET
    |=> (cntEn & $past(regWrData & IMPL_MASK)) == $past(regWrData & IMPL_MASK));

  assert_unimpl_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    (cntEn & ~IMPL_MASK) == 32'h0 && (intEn & ~IMPL_MASK) == 32'h0);

  assert_irq_needs_ovf_R5: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> ovfStatus != 32'h0);

endmodule

// File: rtl/cluster_perf_monitor.sv
module cluster_perf_monitor
  import pmon_pkg::*;
#(
  parameter int          NUM_CNT   = 6,
  parameter logic [7:0]  ID_CODE   = 8'h21,
  parameter logic [7:0]  IMPL_CODE = 8'h41,
  parameter logic [63:0] EVT_AVAIL = 64'h0000_1E00_6602_0000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [63:0] evtIn,
  input  logic        regWrEn,
  input  logic        regRdEn,
  input  logic [6:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        irqOut
);

  pmon_strobe_t              strobe;
  logic [31:0]               runMask;
  logic [NUM_CNT-1:0][7:0]   evtType;
  logic [NUM_CNT-1:0][31:0]  evtCnt;
  logic [63:0]               cycCnt;
  logic [31:0]               ovfStatus;

  pmon_ctrl #(
    .NUM_CNT(NUM_CNT), .ID_CODE(ID_CODE), .IMPL_CODE(IMPL_CODE), .EVT_AVAIL(EVT_AVAIL)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .evtCnt(evtCnt), .cycCnt(cycCnt),
    .ovfStatus(ovfStatus), .strobe(strobe), .runMask(runMask), .evtType(evtType),
    .irqOut(irqOut)
  );

  pmon_datapath #(
    .NUM_CNT(NUM_CNT), .EVT_AVAIL(EVT_AVAIL)
  ) u_dp (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .strobe(strobe), .runMask(runMask),
    .evtType(evtType), .evtCnt(evtCnt), .cycCnt(cycCnt), .ovfStatus(ovfStatus)
  );

endmodule

// File: tb/cluster_perf_monitor_test.sv
module cluster_perf_monitor_test;

  localparam int NCNT = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] evtIn = '0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [6:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        irqOut;

  int tests = 0;
  int fails = 0;
  bit finished = 0;
  logic [63:0] avail;

  always #5 clk = ~clk;

  cluster_perf_monitor #(.NUM_CNT(NCNT)) uut (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData), .irqOut(irqOut)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, input logic [31:0] exp, input string req);
    regRdEn = 1'b1; regAddr = a;
    #1 check(regRdData, exp, req);
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic pulse(input logic [63:0] pat, input int cycles);
    evtIn = pat;
    repeat (cycles) @(negedge clk);
    evtIn = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    avail = '0;
    avail[8'h11] = 1'b1; avail[8'h19] = 1'b1; avail[8'h1A] = 1'b1;
    avail[8'h1D] = 1'b1; avail[8'h1E] = 1'b1;
    for (int k = 8'h29; k <= 8'h2C; k++) avail[k] = 1'b1;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state and layout
    rd(7'h00, {8'h41, 8'h21, 5'(NCNT), 11'b0}, "R1");
    rd(7'h01, 32'h0, "R10");
    rd(7'h05, 32'h0, "R4");
    check({31'b0, irqOut}, 32'h0, "R5");

    // R10 set/clear masks, unimplemented bits
    wr(7'h01, 32'hFFFF_FFFF);
    rd(7'h01, 32'h8000_000F, "R10");
    wr(7'h02, 32'hFFFF_FFFF);
    rd(7'h02, 32'h0, "R10");
    wr(7'h03, 32'h0000_0003);
    rd(7'h04, 32'h0000_0003, "R10");
    wr(7'h04, 32'hFFFF_FFFF);

    // R9 availability words
    rd(7'h06, avail[31:0], "R9");
    rd(7'h07, avail[63:32], "R9");

    // R2 / R9 / R6 code sweep on counter 0
    wr(7'h00, 32'h1);
    wr(7'h01, 32'h1);
    for (int code = 0; code < 66; code++) begin
      logic [7:0] c;
      logic [31:0] exp;
      c = (code < 64) ? 8'(code) : ((code == 64) ? 8'h40 : 8'hFF);
      wr(7'h40, {24'b0, c});
      wr(7'h20, 32'h0);
      pulse('1, 5);
      if (c == 8'h11) exp = 5;
      else if (c == 8'h1E) exp = 0;
      else if (c < 8'h40 && avail[c[5:0]]) exp = 5;
      else exp = 0;
      rd(7'h20, exp, (c == 8'h1E) ? "R6" : "R9");
    end

    // R2 gating by global enable and per-counter enable
    wr(7'h40, 32'h19);
    wr(7'h00, 32'h0);
    wr(7'h20, 32'h0);
    pulse('1, 5);
    rd(7'h20, 32'h0, "R2");
    wr(7'h00, 32'h1);
    wr(7'h02, 32'h1);
    pulse('1, 5);
    rd(7'h20, 32'h0, "R2");
    wr(7'h01, 32'h1);
    pulse(64'h0200_0000, 3);
    rd(7'h20, 32'd3, "R2");

    // R8 write wins over increment
    wr(7'h40, 32'h11);
    wr(7'h20, 32'd100);
    rd(7'h20, 32'd100, "R8");
    rd(7'h20, 32'd101, "R2");

    // R7 reset bits
    wr(7'h00, 32'h3);
    rd(7'h20, 32'h0, "R7");
    rd(7'h00, {8'h41, 8'h21, 5'(NCNT), 10'b0, 1'b1}, "R1");
    wr(7'h01, 32'h8000_0000);
    wr(7'h00, 32'h5);
    rd(7'h08, 32'h0, "R7");
    repeat (3) @(negedge clk);
    rd(7'h08, 32'd4, "R11");

    // R3 / R5 / R6 chain pair
    wr(7'h02, 32'hFFFF_FFFF);
    wr(7'h03, 32'h1);
    wr(7'h40, 32'h19);
    wr(7'h41, 32'h1E);
    wr(7'h42, 32'h1E);
    wr(7'h20, 32'hFFFF_FFFE);
    wr(7'h21, 32'd7);
    wr(7'h22, 32'h0);
    wr(7'h01, 32'h7);
    pulse(64'h0200_0000, 3);
    #1 check({31'b0, irqOut}, 32'h1, "R5");
    rd(7'h20, 32'd1, "R3");
    rd(7'h21, 32'd8, "R6");
    rd(7'h22, 32'd0, "R6");
    wr(7'h02, 32'h1);
    #1 check({31'b0, irqOut}, 32'h0, "R5");
    rd(7'h05, 32'h1, "R4");
    rd(7'h05, 32'h0, "R4");

    // R4 overflow on the clearing edge stays set
    wr(7'h41, 32'h11);
    wr(7'h01, 32'h2);
    wr(7'h21, 32'hFFFF_FFFF);
    rd(7'h05, 32'h0, "R4");
    rd(7'h05, 32'h2, "R4");
    wr(7'h02, 32'hFFFF_FFFF);

    // R3 / R11 cycle counter wrap
    wr(7'h09, 32'hFFFF_FFFF);
    wr(7'h08, 32'hFFFF_FFFE);
    rd(7'h09, 32'hFFFF_FFFF, "R11");
    wr(7'h01, 32'h8000_0000);
    repeat (2) @(negedge clk);
    rd(7'h05, 32'h8000_0000, "R3");
    rd(7'h09, 32'h0, "R3");
    rd(7'h08, 32'd2, "R11");

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule